// File: doc/BRIEF.md
# Video Control Signal Conditioner

This block sits on the pixel clock ahead of a serial link and cleans up the three slow video control lines (horizontal sync, vertical sync and data enable) before they are packed into the link payload. Each line passes through a short delay line that can reject pulses narrower than three clocks, and then through a rate limiter that only lets a fixed number of transitions through in any window of 130 clocks. A transition that arrives while the budget is used up is held back, and the output moves to the line's current level as soon as the window opens again.

A 2-bit mode input picks the behaviour: raw-rate mode keeps the rate limits but drops the width filter, filtered mode applies both, and the two compatibility modes pass the lines through unchanged. The latency from input to output is the same four clocks in every mode, so a mode change never shifts the control lines against pixel data carried on a matching pipeline.

Top module: `ctrl_sig_conditioner`

## Requirements
- R1: Bit 0 of the control vector is horizontal sync, bit 1 is vertical sync and bit 2 is data enable; each bit is conditioned independently with the budget of the signal it carries.
- R2: While rst_ni is low all outputs are 0, and after reset every signal has its full transition budget.
- R3: In mode 2'b01 an output bit takes a new level only once the input has held that level on 3 consecutive clock samples; pulses of 1 or 2 clocks never reach the output.
- R4: In mode 2'b00 there is no minimum width: a 1-clock input pulse reaches the output as a 1-clock pulse when budget is available.
- R5: In modes 2'b00 and 2'b01, data enable and horizontal sync each change at most 2 times in any 130 consecutive clocks.
- R6: In modes 2'b00 and 2'b01, vertical sync changes at most once in any 130 consecutive clocks, so every vertical sync output pulse is at least 130 clocks wide.
- R7: A change blocked by the budget leaves the output at its last level; the output takes the current target level in the first clock in which the window frees a transition.
- R8: In modes 2'b10 and 2'b11 each output bit copies its input with no width filtering and no rate limit.
- R9: Input-to-output latency is 4 clocks in every mode: an input sampled at clock edge k appears at the output after edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 raw-rate, 01 filtered, 10/11 compatibility pass-through |
| ctrl_i | input | 3 | Raw control bits {DE, VS, HS} |
| ctrl_o | output | 3 | Conditioned control bits {DE, VS, HS} |

## Verification
Every result of this block is due a fixed number of edges after its stimulus: an unfiltered change four edges after it is sampled, a filtered change after its third stable sample plus one edge, and a budget-blocked change exactly 130 edges after the transition whose slot it reuses. The bench drives inputs on the falling edge and compares the outputs on the next falling edge against a cycle model advanced once per drive, so each comparison sees the state left by the rising edge in between. Directed sequences pin the exact step at which each of those edges lands (for example the 135th step of a blocked-hold run) and compare there.

// File: rtl/ctrl_filt_pkg.sv
package ctrl_filt_pkg;
  typedef enum logic [1:0] {
    MODE_RAW   = 2'b00,
    MODE_FILT  = 2'b01,
    MODE_LEG_A = 2'b10,
    MODE_LEG_B = 2'b11
  } ctrl_mode_e;

  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CH_HS  = 0;
  localparam int unsigned CH_VS  = 1;
  localparam int unsigned CH_DE  = 2;
endpackage

// File: rtl/ctrl_glitch_stage.sv
module ctrl_glitch_stage #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic filt_en_i,
  input  logic held_i,
  output logic want_o
);
  logic [FILT_LEN-1:0] dly_q;
  logic all_hi, all_lo;

  // dly_q[0] newest sample, dly_q[FILT_LEN-1] oldest
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= {dly_q[FILT_LEN-2:0], sig_i};
  end

  assign all_hi = &dly_q;
  assign all_lo = ~|dly_q;

  always_comb begin
    if (filt_en_i) begin
      if (all_hi)      want_o = 1'b1;
      else if (all_lo) want_o = 1'b0;
      else             want_o = held_i;
    end else begin
      want_o = dly_q[FILT_LEN-1];
    end
  end
endmodule

// File: rtl/ctrl_rate_limiter.sv
module ctrl_rate_limiter #(
  parameter int unsigned WIN    = 130,
  parameter int unsigned BUDGET = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic bypass_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(WIN);

  logic [CW-1:0] slot_q [BUDGET];
  logic          level_q;
  logic          free;
  int unsigned   pick;
  logic          take;

  // lowest idle slot wins
  always_comb begin
    free = 1'b0;
    pick = 0;
    for (int unsigned i = 0; i < BUDGET; i++) begin
      if (!free && slot_q[i] == '0) begin
        free = 1'b1;
        pick = i;
      end
    end
  end

  assign take = !bypass_i && (want_i != level_q) && free;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      for (int unsigned i = 0; i < BUDGET; i++) slot_q[i] <= '0;
    end else begin
      if (bypass_i || take) level_q <= want_i;
      for (int unsigned i = 0; i < BUDGET; i++) begin
        if (take && pick == i)    slot_q[i] <= CW'(WIN - 1);
        else if (slot_q[i] != '0) slot_q[i] <= slot_q[i] - 1'b1;
      end
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/ctrl_sig_conditioner.sv
module ctrl_sig_conditioner
  import ctrl_filt_pkg::*;
#(
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned WIN         = 130,
  parameter int unsigned FAST_BUDGET = 2,
  parameter int unsigned SLOW_BUDGET = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic [2:0] ctrl_i,
  output logic [2:0] ctrl_o
);
  ctrl_mode_e mode;
  logic       filt_en;
  logic       bypass;

  assign mode    = ctrl_mode_e'(mode_i);
  assign filt_en = (mode == MODE_FILT);
  assign bypass  = (mode == MODE_LEG_A) || (mode == MODE_LEG_B);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned CH_BUDGET = (c == CH_VS) ? SLOW_BUDGET : FAST_BUDGET;
    logic want;

    ctrl_glitch_stage #(
      .FILT_LEN (FILT_LEN)
    ) u_glitch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .sig_i     (ctrl_i[c]),
      .filt_en_i (filt_en),
      .held_i    (ctrl_o[c]),
      .want_o    (want)
    );

    ctrl_rate_limiter #(
      .WIN    (WIN),
      .BUDGET (CH_BUDGET)
    ) u_limit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .want_i   (want),
      .bypass_i (bypass),
      .level_o  (ctrl_o[c])
    );
  end
endmodule

// File: rtl/ctrl_sig_conditioner_chk.sv
module ctrl_sig_conditioner_chk #(
  parameter int unsigned FILT_LEN = 3,
  parameter int unsigned WIN      = 130
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic [2:0] ctrl_i,
  input logic [2:0] ctrl_o
);
  localparam int unsigned AW  = $clog2(WIN + 1);
  localparam int unsigned LAT = FILT_LEN + 1;

  logic [2:0]    prev_q;
  logic [2:0]    chg;
  logic [AW-1:0] age1_q [3];
  logic [AW-1:0] age2_q [3];
  logic [1:0]    mode_prev_q;
  logic          mode_moved_q;
  logic          leg_q;
  logic [2:0]    hist_q [LAT];
  logic          rate_on;
  logic          filt_on;

  assign chg     = ctrl_o ^ prev_q;
  assign rate_on = !mode_moved_q && !mode_i[1];
  assign filt_on = !mode_moved_q && (mode_i == 2'b01);

  always_ff @(posedge clk_i) mode_prev_q <= mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q       <= '0;
      mode_moved_q <= 1'b0;
      leg_q        <= 1'b0;
      for (int i = 0; i < 3; i++) begin
        age1_q[i] <= AW'(WIN);
        age2_q[i] <= AW'(WIN);
      end
      for (int i = 0; i < LAT; i++) hist_q[i] <= '0;
    end else begin
      prev_q <= ctrl_o;
      leg_q  <= mode_i[1];
      if (mode_i != mode_prev_q) mode_moved_q <= 1'b1;
      hist_q[0] <= ctrl_i;
      for (int i = 1; i < LAT; i++) hist_q[i] <= hist_q[i-1];
      for (int i = 0; i < 3; i++) begin
        if (chg[i]) begin
          age1_q[i] <= AW'(1);
          age2_q[i] <= (age1_q[i] >= AW'(WIN)) ? AW'(WIN) : age1_q[i] + 1'b1;
        end else begin
          if (age1_q[i] < AW'(WIN)) age1_q[i] <= age1_q[i] + 1'b1;
          if (age2_q[i] < AW'(WIN)) age2_q[i] <= age2_q[i] + 1'b1;
        end
      end
    end
  end

  // R2
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> ctrl_o == 3'b000);

  // R5
  hs_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_on && chg[0]) |-> age2_q[0] >= AW'(WIN));

  // R5
  de_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_on && chg[2]) |-> age2_q[2] >= AW'(WIN));

  // R6
  vs_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_on && chg[1]) |-> age1_q[1] >= AW'(WIN));

  // R3
  min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_on && |chg) |-> ((!chg[0] || age1_q[0] >= AW'(FILT_LEN)) &&
                           (!chg[2] || age1_q[2] >= AW'(FILT_LEN))));

  // R8 R9
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    leg_q |-> ctrl_o == hist_q[LAT-1]);
endmodule

bind ctrl_sig_conditioner ctrl_sig_conditioner_chk #(
  .FILT_LEN (FILT_LEN),
  .WIN      (WIN)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .mode_i (mode_i),
  .ctrl_i (ctrl_i),
  .ctrl_o (ctrl_o)
);

// File: tb/ctrl_sig_conditioner_bench.sv
module ctrl_sig_conditioner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 130;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [2:0] ctrl_i = 3'b000;
  logic [2:0] ctrl_o;

  int checks = 0;
  int fails  = 0;

  logic [2:0] m_h0, m_h1, m_h2, m_out;
  int         m_slot [3][2];
  logic [2:0] drv [0:63];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ctrl_sig_conditioner u_ctrl_sig_conditioner (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .ctrl_i (ctrl_i),
    .ctrl_o (ctrl_o)
  );

  function automatic logic f_want(logic a, logic b, logic c, logic held, logic [1:0] md);
    if (md == 2'b01) begin
      if (a && b && c)    return 1'b1;
      if (!a && !b && !c) return 1'b0;
      return held;
    end
    return c;
  endfunction

  function automatic int f_budget(int ch);
    return (ch == 1) ? 1 : 2;
  endfunction

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: ctrl_o=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_h0 = '0; m_h1 = '0; m_h2 = '0; m_out = '0;
    for (int c = 0; c < 3; c++) for (int s = 0; s < 2; s++) m_slot[c][s] = 0;
  endtask

  task automatic model_tick(logic [2:0] v, logic [1:0] md);
    logic [2:0] nout;
    nout = m_out;
    for (int c = 0; c < 3; c++) begin
      logic w;
      int   pick;
      w = f_want(m_h0[c], m_h1[c], m_h2[c], m_out[c], md);
      pick = -1;
      for (int s = 0; s < f_budget(c); s++) if (pick < 0 && m_slot[c][s] == 0) pick = s;
      for (int s = 0; s < f_budget(c); s++) if (m_slot[c][s] > 0) m_slot[c][s]--;
      if (md[1]) nout[c] = w;
      else if (w != m_out[c] && pick >= 0) begin
        nout[c] = w;
        m_slot[c][pick] = WIN - 1;
      end
    end
    m_out = nout;
    m_h2 = m_h1; m_h1 = m_h0; m_h0 = v;
  endtask

  // compare, optionally check a directed value, then drive the next input
  task automatic step(logic [2:0] v, string tag, bit dchk = 1'b0, logic [2:0] dexp = 3'b000);
    @(negedge clk_i);
    check(tag, ctrl_o, m_out);
    if (dchk) check(tag, ctrl_o, dexp);
    ctrl_i = v;
    model_tick(v, mode_i);
  endtask

  task automatic do_reset(logic [1:0] md);
    @(negedge clk_i);
    rst_ni = 1'b0;
    ctrl_i = '0;
    mode_i = md;
    repeat (3) @(negedge clk_i);
    check("R2", ctrl_o, 3'b000);
    rst_ni = 1'b1;
    model_reset();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));

    // latency, raw pulse, blocked change (HS)
    do_reset(2'b00);
    for (int n = 1; n <= 140; n++) begin
      logic [2:0] v;
      v = (n == 1 || n >= 7) ? 3'b001 : 3'b000;
      if (n == 5)        step(v, "R9", 1'b1, 3'b001);
      else if (n == 6)   step(v, "R4", 1'b1, 3'b000);
      else if (n == 134) step(v, "R7", 1'b1, 3'b000);
      else if (n == 135) step(v, "R7", 1'b1, 3'b001);
      else               step(v, "R5");
    end

    // bit mapping and VS single-transition budget
    do_reset(2'b00);
    for (int n = 1; n <= 140; n++) begin
      logic [2:0] v;
      v = (n == 1) ? 3'b011 : 3'b000;
      if (n == 5)        step(v, "R1", 1'b1, 3'b011);
      else if (n == 6)   step(v, "R1", 1'b1, 3'b010);
      else if (n == 134) step(v, "R6", 1'b1, 3'b010);
      else if (n == 135) step(v, "R6", 1'b1, 3'b000);
      else               step(v, "R6");
    end

    // width filter: 2-clock pulse dropped, 3-clock pulse kept
    do_reset(2'b01);
    for (int n = 1; n <= 24; n++) begin
      logic [2:0] v;
      v = (n <= 2 || (n >= 11 && n <= 13)) ? 3'b001 : 3'b000;
      if (n >= 3 && n <= 10)  step(v, "R3", 1'b1, 3'b000);
      else if (n == 15)       step(v, "R3", 1'b1, 3'b001);
      else if (n == 17)       step(v, "R3", 1'b1, 3'b001);
      else if (n == 18)       step(v, "R3", 1'b1, 3'b000);
      else                    step(v, "R3");
    end

    // compatibility pass-through, fast toggling
    do_reset(2'b10);
    for (int n = 1; n <= 60; n++) begin
      logic [2:0] v;
      v = 3'($urandom());
      drv[n] = v;
      if (n >= 5) step(v, "R8", 1'b1, drv[n-4]);
      else        step(v, "R8");
    end

    // random runs per mode
    for (int m = 0; m < 3; m++) begin
      logic [1:0] md;
      logic [2:0] cur;
      md = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b11;
      do_reset(md);
      cur = '0;
      for (int n = 0; n < 2500; n++) begin
        for (int b = 0; b < 3; b++) if ($urandom() % 6 == 0) cur[b] = ~cur[b];
        if (m == 0)      step(cur, "R5");
        else if (m == 1) step(cur, "R3");
        else             step(cur, "R8");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule